// File: doc/BRIEF.md
# I2C Bus Status Flag Monitor

This block listens to the clock and data lines of an I2C bus without driving them. It keeps an 8-bit status word with three sticky flags. The first says a start condition has opened a transfer. The second says a stop condition has released the bus. The third says a receiver pulled the data line low on the ninth clock of a byte. Each flag has its own clear rules. These rules depend on where the bus is in its byte sequence, on a one-cycle release pulse and on the falling edge of an enable level. Software-facing logic can therefore read the word at any time and learn what the bus last did. Bits 7 to 3 belong to functions that are not built here (bus driving, arbitration, address matching, direction) and always read zero.

Both bus lines pass through a two-flop synchronizer. A third flop keeps the previous synchronized sample, so that edges can be found. A phase machine with three states, `PH_IDLE`, `PH_ADDR` and `PH_DATA`, tracks the transfer. A start condition moves it from any state to `PH_ADDR` and zeroes the clock counter. A stop condition moves it from any state to `PH_IDLE`. The first rising clock of the byte after the address byte moves it from `PH_ADDR` to `PH_DATA`. Enable low forces `PH_IDLE`. In the busy states a 4-bit counter counts rising clock edges from 1 to 9. A rising edge after the ninth counts as clock 1 of the next byte. Flags update three system clocks after a bus line changes: two synchronizer stages, then the flag register.

Top module: `i2c_status_monitor`

## Requirements
- R1: After synchronous reset the status word is 0x00, and bits 7..3 read zero at all times.
- R2: A start condition (SDA falls while SCL is high) sets status bit 1, the start flag, and begins an address byte.
- R3: A stop condition (SDA rises while SCL is high) sets status bit 0, the stop flag, and clears bit 1 and bit 2.
- R4: At the ninth rising SCL edge of a byte, status bit 2, the acknowledge flag, sets if SDA is low; if SDA is high it is left unchanged.
- R5: The acknowledge flag clears at the first rising SCL edge of the byte that follows.
- R6: The start flag stays set through the whole address byte and clears at the first rising SCL edge of the byte after it.
- R7: The stop flag survives a new start condition and clears at the first rising SCL edge of the address byte after that start.
- R8: A one-cycle release pulse clears the start and acknowledge flags and leaves the stop flag unchanged.
- R9: While enable is low all three flags read zero and bus events have no effect; enable falling clears every flag.
- R10: A start condition seen while a transfer is under way (repeated start) restarts the address byte and the clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| enable | input | 1 | Monitor enable level |
| release_pulse | input | 1 | One-cycle pulse clearing start and acknowledge flags |
| status | output | 8 | Status word: bit 2 acknowledge, bit 1 start, bit 0 stop, bits 7..3 zero |

## Verification
The bench sweeps whole transfers. It tries each combination of address acknowledge (low or high), data acknowledge (low or high) and zero to two data bytes. This separates ack-driven setting from byte-boundary clearing, and an address-only transfer from one with data. Further sequences apply a release pulse both mid-transfer and after a stop, which separates the start and acknowledge flags from the stop flag. Others issue a repeated start in the middle of a data byte, which shows the address phase restarts, and drop enable mid-transfer, which shows that the flags are forced to zero and that bus activity is ignored until a new start.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_e;

    localparam int STAT_W  = 8;
    localparam int FLAG_N  = 3;
    localparam int ACK_POS = 2;
    localparam int STA_POS = 1;
    localparam int STO_POS = 0;

    typedef struct packed {
        logic start;       // start condition seen
        logic stop;        // stop condition seen
        logic first_addr;  // first clock of address byte
        logic first_next;  // first clock of byte after a completed byte
        logic leave_addr;  // first clock of byte after address byte
        logic ack_seen;    // ninth clock with data low
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] sync,
    output logic [LINES-1:0] prev
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-1:0], raw[g]};
            end
            assign sync[g] = sh[STAGES-1];
            assign prev[g] = sh[STAGES];
        end
    endgenerate
endmodule

// File: rtl/i2c_phase_fsm.sv
module i2c_phase_fsm
    import i2c_mon_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int BITS_PER_BYTE = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             scl_s,
    input  logic             scl_p,
    input  logic             sda_s,
    input  logic             sda_p,
    output bus_evt_t         evt,
    output bus_phase_e       phase,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    bus_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             scl_hi, start_c, stop_c, rise_c;

    assign scl_hi  = scl_s & scl_p;
    assign start_c = enable & scl_hi & sda_p & ~sda_s;
    assign stop_c  = enable & scl_hi & ~sda_p & sda_s;
    assign rise_c  = enable & scl_s & ~scl_p & (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (start_c) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
        end else if (stop_c) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (rise_c) begin
            cnt_d = (cnt_q == LAST) ? ONE : cnt_q + ONE;
            unique case (phase_q)
                PH_ADDR: if (cnt_q == LAST) phase_d = PH_DATA;
                PH_DATA: phase_d = PH_DATA;
                PH_IDLE: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        evt            = '0;
        evt.start      = start_c;
        evt.stop       = stop_c;
        evt.first_addr = rise_c & (cnt_q == '0) & (phase_q == PH_ADDR);
        evt.first_next = rise_c & (cnt_q == LAST);
        evt.leave_addr = rise_c & (cnt_q == LAST) & (phase_q == PH_ADDR);
        evt.ack_seen   = rise_c & (cnt_q == PRE_LAST) & ~sda_s;
    end

    assign phase   = phase_q;
    assign bit_cnt = cnt_q;
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
    import i2c_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              release_pulse,
    input  bus_evt_t          evt,
    output logic [FLAG_N-1:0] flags
);
    logic [FLAG_N-1:0] flags_q, flags_d;
    logic              rel;

    assign rel = enable & release_pulse;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    always_comb begin
        flags_d = flags_q;
        if (!enable) begin
            flags_d = '0;
        end else begin
            if (evt.stop || evt.first_next || rel) flags_d[ACK_POS] = 1'b0;
            if (evt.ack_seen)                      flags_d[ACK_POS] = 1'b1;

            if (evt.stop || evt.leave_addr || rel) flags_d[STA_POS] = 1'b0;
            if (evt.start)                         flags_d[STA_POS] = 1'b1;

            if (evt.first_addr)                    flags_d[STO_POS] = 1'b0;
            if (evt.stop)                          flags_d[STO_POS] = 1'b1;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/i2c_status_monitor.sv
module i2c_status_monitor
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_BYTE = 9,
    parameter int CNT_W         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              enable,
    input  logic              release_pulse,
    output logic [STAT_W-1:0] status
);
    logic [1:0]        line_sync, line_prev;
    bus_evt_t          evt;
    bus_phase_e        phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [FLAG_N-1:0] flags;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({scl_in, sda_in}),
        .sync (line_sync),
        .prev (line_prev)
    );

    i2c_phase_fsm #(.CNT_W(CNT_W), .BITS_PER_BYTE(BITS_PER_BYTE)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .scl_s   (line_sync[1]),
        .scl_p   (line_prev[1]),
        .sda_s   (line_sync[0]),
        .sda_p   (line_prev[0]),
        .evt     (evt),
        .phase   (phase),
        .bit_cnt (bit_cnt)
    );

    i2c_flag_regs u_flags (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .release_pulse (release_pulse),
        .evt           (evt),
        .flags         (flags)
    );

    always_comb begin
        status         = '0;
        status[FLAG_N-1:0] = flags;
    end
endmodule

// File: rtl/i2c_status_monitor_chk.sv
module i2c_status_monitor_chk
    import i2c_mon_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int BITS_PER_BYTE = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              release_pulse,
    input logic [STAT_W-1:0] status,
    input bus_evt_t          evt,
    input bus_phase_e        phase,
    input logic [CNT_W-1:0]  bit_cnt
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[STAT_W-1:FLAG_N] == '0);

    p_start_sets_r2: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> status[STA_POS]);

    p_stop_sets_r3: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (status[STO_POS] && !status[STA_POS] && !status[ACK_POS]));

    p_ack_sets_r4: assert property (@(posedge clk) disable iff (rst)
        evt.ack_seen |=> status[ACK_POS]);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(BITS_PER_BYTE));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        evt.first_next |=> !status[ACK_POS]);

    p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
        evt.leave_addr |=> (!status[STA_POS] && phase == PH_DATA));

    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        evt.first_addr |=> !status[STO_POS]);

    p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && release_pulse && !evt.start && !evt.ack_seen)
        |=> (!status[STA_POS] && !status[ACK_POS]));

    p_release_keeps_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && release_pulse && status[STO_POS] && !evt.first_addr)
        |=> status[STO_POS]);

    p_disabled_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (status[FLAG_N-1:0] == '0 && phase == PH_IDLE));

    p_restart_addr_r10: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (phase == PH_ADDR && bit_cnt == '0));
endmodule

bind i2c_status_monitor i2c_status_monitor_chk #(
    .CNT_W(CNT_W), .BITS_PER_BYTE(BITS_PER_BYTE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .release_pulse (release_pulse),
    .status        (status),
    .evt           (evt),
    .phase         (phase),
    .bit_cnt       (bit_cnt)
);

// File: tb/tb_i2c_status_monitor.sv
module tb_i2c_status_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       enable = 1'b0;
    logic       release_pulse = 1'b0;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;

    // bench model of the flags, built from the requirements
    bit m_en, m_ack, m_sta, m_sto, m_busy, m_addr;
    int m_cnt;

    always #4 clk = ~clk;   // 125 MHz

    i2c_status_monitor dut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .enable        (enable),
        .release_pulse (release_pulse),
        .status        (status)
    );

    task automatic check(input logic [7:0] exp, input string tag);
        total++;
        if (status !== exp) begin
            bad++;
            $display("FAIL %s: status=%02h expected=%02h at %0t", tag, status, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_word();
        return {5'b0, m_ack, m_sta, m_sto};
    endfunction

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lines(input bit ns, input bit nd);
        string tag = "R9";
        if (m_en) tag = "R1";
        if (m_en && scl_in && ns && (sda_in != nd)) begin
            if (!nd) begin
                tag = m_busy ? "R10" : "R2";
                m_sta = 1; m_busy = 1; m_addr = 1; m_cnt = 0;
            end else begin
                tag = "R3";
                m_sta = 0; m_ack = 0; m_sto = 1; m_busy = 0; m_addr = 0; m_cnt = 0;
            end
        end else if (m_en && !scl_in && ns && m_busy) begin
            tag = "R4";
            if (m_cnt == 9) begin
                m_ack = 0; tag = "R5";
                if (m_addr) begin m_sta = 0; m_addr = 0; tag = "R6"; end
            end else if (m_cnt == 0 && m_addr) begin
                m_sto = 0; tag = "R7";
            end
            m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
            if (m_cnt == 9 && !nd) m_ack = 1;
        end
        scl_in = ns;
        sda_in = nd;
        settle();
        check(model_word(), tag);
    endtask

    task automatic do_start();
        set_lines(scl_in, 1);
        set_lines(1, 1);
        set_lines(1, 0);
        set_lines(0, 0);
    endtask

    task automatic do_stop();
        set_lines(0, 0);
        set_lines(1, 0);
        set_lines(1, 1);
    endtask

    task automatic send_bit(input bit b);
        set_lines(0, b);
        set_lines(1, b);
        set_lines(0, b);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit ack_high);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(ack_high);
    endtask

    task automatic pulse_release();
        release_pulse = 1'b1;
        @(negedge clk);
        release_pulse = 1'b0;
        if (m_en) begin m_sta = 0; m_ack = 0; end
        settle();
        check(model_word(), "R8");
    endtask

    task automatic set_enable(input bit e);
        enable = e;
        m_en = e;
        if (!e) begin
            m_sta = 0; m_ack = 0; m_sto = 0; m_busy = 0; m_addr = 0; m_cnt = 0;
        end
        settle();
        check(model_word(), "R9");
    endtask

    initial begin
        repeat (3_000_00 / 2) @(posedge clk);
        bad++;
        $display("FAIL watchdog: status=%02h expected=done", status);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_en = 0; m_ack = 0; m_sta = 0; m_sto = 0; m_busy = 0; m_addr = 0; m_cnt = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(8'h00, "R1 in reset");
        rst = 1'b0;
        settle();
        check(8'h00, "R1 after reset");

        // R9: disabled monitor ignores a whole transfer
        do_start();
        send_byte(8'h5A, 0);
        do_stop();
        check(8'h00, "R9 ignored");

        set_enable(1);

        // sweep: address ack, data ack, data byte count
        for (int aa = 0; aa < 2; aa++) begin
            for (int da = 0; da < 2; da++) begin
                for (int nb = 0; nb < 3; nb++) begin
                    do_start();
                    send_byte(8'hA0 | 8'(nb), aa[0]);
                    for (int k = 0; k < nb; k++)
                        send_byte(8'h3C ^ 8'(k * 17), da[0]);
                    do_stop();
                end
            end
        end

        // R8: release mid-transfer clears start and ack
        do_start();
        send_byte(8'h90, 0);
        pulse_release();
        send_byte(8'h11, 0);
        pulse_release();
        do_stop();
        // R8: release after stop keeps the stop flag
        pulse_release();
        check(8'h01, "R8 stop kept");

        // R10: repeated start in the middle of a data byte
        do_start();
        send_byte(8'h44, 0);
        send_bit(1); send_bit(0); send_bit(1);
        do_start();
        check(8'h02, "R10 restart");
        send_byte(8'h45, 0);
        send_byte(8'h77, 1);
        do_stop();

        // R9: enable falls mid-transfer
        do_start();
        send_byte(8'hB2, 0);
        set_enable(0);
        check(8'h00, "R9 enable fall");
        send_byte(8'h00, 0);
        do_stop();
        check(8'h00, "R9 held low");
        set_enable(1);
        do_start();
        check(8'h02, "R2 after re-enable");
        send_byte(8'hC1, 0);
        do_stop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule